// File: doc/BRIEF.md
# Link self-test pattern generator and checker

This block adds a built-in self-test path to a byte-wide serial link. On the transmit side, driving the active-low test enable low makes the block send a fixed pseudo-random character sequence in place of the system's data. The sequence repeats every 511 characters. For as long as the test runs, read requests toward the transmit FIFO are held off, so no queued data is consumed or lost. Releasing the enable hands the character path back to the FIFO data in the same cycle.

On the receive side, a separate active-low enable starts the checker. The checker first follows the incoming characters until it has seen a run of consecutive characters that fit the sequence. From then on it predicts each character on its own and compares. Every wrong character gives a one-cycle pulse on the received-violation output. Outside the test, that output simply forwards the violation indication from the decoding logic. A saturating error count is kept alongside. Transmit and receive share one clock, and one received character is presented per cycle that `rx_valid_i` is high.

Top module: `link_bist`

## Requirements
- R1: While `tx_bist_en_ni` is low, `tx_char_o` carries the low 8 bits of a 9-bit shift state s that steps once per clock. The step is s' = {s[7:0], s[8]^s[4]} (polynomial x^9+x^5+1). In the first cycle of every test run, s is 9'h1FF, so that cycle shows 8'hFF. The output repeats with a period of 511 characters.
- R2: While `tx_bist_en_ni` is low, `tx_fifo_rd_o` is 0 whatever `tx_rd_req_i` does.
- R3: While `tx_bist_en_ni` is high, `tx_char_o` equals `tx_data_i` and `tx_fifo_rd_o` equals `tx_rd_req_i` in the same cycle.
- R4: While `rx_bist_en_ni` is high, `rx_viol_o` equals `rx_viol_i` in the same cycle. From the next clock edge, `rx_sync_o` is 0 and `err_cnt_o` is 0.
- R5: The checker keeps a 9-bit state t, cleared when the test is off. A received character c, accepted when `rx_valid_i` is high, fits when t is nonzero and c equals the low 8 bits of t stepped as in R1. Before lock, t becomes {t[7], c} after each accepted character. `rx_sync_o` rises in the cycle after the 9th consecutive fitting character. No violation is flagged before lock.
- R6: An all-zero tracked state never counts as fitting, so a stream of 8'h00 characters never locks.
- R7: After lock, t steps once per accepted character. When the accepted character differs from the low 8 bits of the stepped t, `rx_viol_o` is 1 for exactly the following cycle. A cycle with `rx_valid_i` low neither steps t nor flags.
- R8: Lock holds until `rx_bist_en_ni` goes high. A single corrupted character gives exactly one pulse, and the correct characters that follow it give none.
- R9: `err_cnt_o` rises by one on the same edge as each flagged violation. It saturates at 65535 and returns to 0 when the receive test is disabled.
- R10: During reset, `rx_sync_o` and `err_cnt_o` are 0, and both the transmit path and the violation output pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Link clock, one character per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_bist_en_ni | input | 1 | Transmit self-test enable, active low |
| tx_rd_req_i | input | 1 | System read request toward the transmit FIFO |
| tx_data_i | input | 8 | Character from the transmit FIFO |
| tx_fifo_rd_o | output | 1 | Gated read strobe to the transmit FIFO |
| tx_char_o | output | 8 | Character to the encoder |
| rx_bist_en_ni | input | 1 | Receive self-test enable, active low |
| rx_valid_i | input | 1 | Received character present this cycle |
| rx_char_i | input | 8 | Received character |
| rx_viol_i | input | 1 | Violation indication from the decoder |
| rx_viol_o | output | 1 | Decoder violation, or test mismatch pulse while testing |
| rx_sync_o | output | 1 | Checker locked to the sequence |
| err_cnt_o | output | 16 | Saturating mismatch count |

## Verification
If the generator's shift state were wrong, the effect would show at once on `tx_char_o`. A missed reseed would show in the first test cycle as something other than 8'hFF. A bad feedback tap would break the 511-character period, which is seen when characters 511 apart are compared. If the checker's tracked state diverged after lock, violation pulses would follow on every character starting one cycle after the divergence, and the error count would climb with them. A fault in the lock counter would show as `rx_sync_o` rising too early or too late against a model that counts fitting characters. It could also show as a lock on an all-zero stream, or as a pulse before lock.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;
  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned LFSR_W   = CHAR_W + 1;
  localparam int unsigned LFSR_TAP = 4;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_TAP]};
  endfunction
endpackage

// File: rtl/link_bist_gen.sv
module link_bist_gen
  import link_bist_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  output logic [CHAR_W-1:0] char_o
);
  logic              run_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] cur;

  // first active cycle uses the seed, never a stale state
  assign cur    = (active_i && !run_q) ? LFSR_SEED : lfsr_q;
  assign char_o = cur[CHAR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      lfsr_q <= LFSR_SEED;
    end else begin
      run_q <= active_i;
      if (active_i) lfsr_q <= lfsr_next(cur);
    end
  end
endmodule

// File: rtl/link_bist_chk.sv
module link_bist_chk
  import link_bist_pkg::*;
#(
  parameter int unsigned SYNC_LEN = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              valid_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic              sync_o,
  output logic              miss_o,
  output logic              flag_o
);
  localparam int unsigned CW = $clog2(SYNC_LEN + 1);

  logic [LFSR_W-1:0] lfsr_q, pred, loaded;
  logic [CW-1:0]     run_q;
  logic              sync_q, flag_q, hit, fits;

  assign pred   = lfsr_next(lfsr_q);
  assign loaded = {lfsr_q[CHAR_W-1], char_i};
  assign hit    = (char_i == pred[CHAR_W-1:0]);
  assign fits   = hit && (lfsr_q != '0);
  assign miss_o = active_i && valid_i && sync_q && !hit;
  assign sync_o = sync_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= '0;
      run_q  <= '0;
      sync_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (!active_i) begin
      lfsr_q <= '0;
      run_q  <= '0;
      sync_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= miss_o;
      if (valid_i) begin
        if (sync_q) begin
          lfsr_q <= pred;
        end else begin
          lfsr_q <= loaded;
          run_q  <= fits ? run_q + 1'b1 : '0;
          if (fits && run_q == CW'(SYNC_LEN - 1)) sync_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/link_bist_errcnt.sv
module link_bist_errcnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/link_bist.sv
module link_bist
  import link_bist_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SYNC_LEN = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_bist_en_ni,
  input  logic              tx_rd_req_i,
  input  logic [CHAR_W-1:0] tx_data_i,
  output logic              tx_fifo_rd_o,
  output logic [CHAR_W-1:0] tx_char_o,
  input  logic              rx_bist_en_ni,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_char_i,
  input  logic              rx_viol_i,
  output logic              rx_viol_o,
  output logic              rx_sync_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic              tx_active, rx_active;
  logic [CHAR_W-1:0] gen_char;
  logic              miss, flag;

  assign tx_active = !tx_bist_en_ni;
  assign rx_active = !rx_bist_en_ni;

  link_bist_gen u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (tx_active),
    .char_o   (gen_char)
  );

  assign tx_char_o    = tx_active ? gen_char : tx_data_i;
  assign tx_fifo_rd_o = tx_rd_req_i && !tx_active;

  link_bist_chk #(.SYNC_LEN(SYNC_LEN)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (rx_active),
    .valid_i  (rx_valid_i),
    .char_i   (rx_char_i),
    .sync_o   (rx_sync_o),
    .miss_o   (miss),
    .flag_o   (flag)
  );

  // shared violation pin: decoder use outside test, mismatch pulse in test
  assign rx_viol_o = rx_active ? flag : rx_viol_i;

  link_bist_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!rx_active),
    .inc_i  (miss),
    .cnt_o  (err_cnt_o)
  );
endmodule

// File: rtl/link_bist_sva.sv
module link_bist_sva
  import link_bist_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_bist_en_ni,
  input logic [CHAR_W-1:0] tx_data_i,
  input logic              tx_fifo_rd_o,
  input logic [CHAR_W-1:0] tx_char_o,
  input logic              rx_bist_en_ni,
  input logic              rx_valid_i,
  input logic              rx_viol_o,
  input logic              rx_sync_o,
  input logic [CNT_W-1:0]  err_cnt_o
);
  AST_TX_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_bist_en_ni) |-> tx_char_o == LFSR_SEED[CHAR_W-1:0]); // R1
  AST_TX_RD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_bist_en_ni |-> !tx_fifo_rd_o); // R2
  AST_TX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_bist_en_ni |-> tx_char_o == tx_data_i); // R3
  AST_RX_OFF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_bist_en_ni |=> (err_cnt_o == '0 && !rx_sync_o)); // R4
  AST_NO_FLAG_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_bist_en_ni && !rx_sync_o) |=> (rx_bist_en_ni || !rx_viol_o)); // R5
  AST_FLAG_NEEDS_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_bist_en_ni && !rx_valid_i) |=> (rx_bist_en_ni || !rx_viol_o)); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_bist_en_ni && rx_sync_o) |=> (rx_bist_en_ni || rx_sync_o)); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_bist_en_ni && $past(!rx_bist_en_ni) && rx_viol_o) |->
    (err_cnt_o == CNT_W'($past(err_cnt_o) + 1'b1) || err_cnt_o == '1)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_bist_en_ni && $past(!rx_bist_en_ni) && !rx_viol_o) |-> $stable(err_cnt_o)); // R9
endmodule

bind link_bist link_bist_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_bist_en_ni (tx_bist_en_ni),
  .tx_data_i     (tx_data_i),
  .tx_fifo_rd_o  (tx_fifo_rd_o),
  .tx_char_o     (tx_char_o),
  .rx_bist_en_ni (rx_bist_en_ni),
  .rx_valid_i    (rx_valid_i),
  .rx_viol_o     (rx_viol_o),
  .rx_sync_o     (rx_sync_o),
  .err_cnt_o     (err_cnt_o)
);

// File: tb/link_bist_tb_top.sv
`timescale 1ns/1ps
module link_bist_tb_top;
  localparam logic [8:0] SEED = 9'h1FF;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_bist_en_ni = 1'b1, tx_rd_req_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic tx_fifo_rd_o;
  logic [7:0] tx_char_o;
  logic rx_bist_en_ni = 1'b1, rx_valid_i = 1'b0, rx_viol_i = 1'b0;
  logic [7:0] rx_char_i;
  logic rx_viol_o, rx_sync_o;
  logic [15:0] err_cnt_o;

  logic loop_mode = 1'b0;
  logic [7:0] mask = '0, src_char = '0;
  assign rx_char_i = loop_mode ? (tx_char_o ^ mask) : src_char;

  always #2.5 clk_i = ~clk_i;

  link_bist dut_i (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] stp(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  // reference model
  logic t_prev = 1'b0;
  logic [8:0] t_st = SEED;
  logic [8:0] m_st = '0;
  int m_run = 0, m_err = 0;
  logic m_sync = 1'b0, m_flag = 1'b0;

  always @(negedge clk_i) begin
    logic act;
    logic [8:0] cur, pr;
    act = !tx_bist_en_ni;
    cur = (act && !t_prev) ? SEED : t_st;
    chk(act ? "R1 tx_char" : "R3 tx_char", tx_char_o, act ? cur[7:0] : tx_data_i);
    chk(act ? "R2 fifo_rd" : "R3 fifo_rd", tx_fifo_rd_o, tx_rd_req_i && !act);
    chk("R7 rx_viol", rx_viol_o, rx_bist_en_ni ? rx_viol_i : m_flag);
    chk("R5 rx_sync", rx_sync_o, m_sync);
    chk("R9 err_cnt", err_cnt_o, m_err);
    if (rst_ni) begin
      if (act) t_st = stp(cur);
      t_prev = act;
      if (rx_bist_en_ni) begin
        m_st = '0; m_run = 0; m_sync = 0; m_err = 0; m_flag = 0;
      end else begin
        m_flag = 0;
        if (rx_valid_i) begin
          pr = stp(m_st);
          if (m_sync) begin
            if (rx_char_i != pr[7:0]) begin
              m_flag = 1;
              if (m_err < 65535) m_err++;
            end
            m_st = pr;
          end else begin
            if (rx_char_i == pr[7:0] && m_st != 0) m_run++; else m_run = 0;
            if (m_run == 9) m_sync = 1;
            m_st = {m_st[7], rx_char_i};
          end
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk_i); #1;
      rx_viol_i   = 1'($urandom);
      tx_data_i   = 8'($urandom);
      tx_rd_req_i = 1'($urandom);
    end
  endtask

  logic [7:0] cap [0:1021];

  initial begin
    #950000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int pulses;
    logic [8:0] src;
    tx_data_i = 8'h5A; rx_viol_i = 1'b1;
    @(negedge clk_i);
    chk("R10 tx pass", tx_char_o, 8'h5A);
    chk("R10 viol pass", rx_viol_o, 1'b1);
    chk("R10 sync", rx_sync_o, 1'b0);
    chk("R10 err", err_cnt_o, 16'h0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    cyc(20);

    tx_bist_en_ni = 1'b0;
    for (int i = 0; i < 1022; i++) begin
      @(negedge clk_i); cap[i] = tx_char_o;
      @(posedge clk_i); #1 tx_rd_req_i = 1'b1; tx_data_i = 8'($urandom);
    end
    chk("R1 seed", cap[0], 8'hFF);
    for (int i = 0; i < 511; i++) chk("R1 period", cap[i + 511], cap[i]);
    tx_bist_en_ni = 1'b1;
    cyc(10);
    tx_bist_en_ni = 1'b0;
    @(negedge clk_i); chk("R1 reseed", tx_char_o, 8'hFF);
    cyc(3);

    loop_mode = 1'b1; rx_valid_i = 1'b1; rx_bist_en_ni = 1'b0;
    cyc(30);
    @(negedge clk_i);
    chk("R5 locked", rx_sync_o, 1'b1);
    chk("R5 no errors", err_cnt_o, 16'h0);
    @(posedge clk_i); #1 mask = 8'h01;
    @(posedge clk_i); #1 mask = 8'h00;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i); if (rx_viol_o) pulses++;
    end
    chk("R8 one pulse", pulses, 1);
    chk("R8 err one", err_cnt_o, 16'h1);
    chk("R8 still locked", rx_sync_o, 1'b1);

    rx_bist_en_ni = 1'b1;
    cyc(20);
    @(negedge clk_i);
    chk("R4 err cleared", err_cnt_o, 16'h0);
    chk("R4 unlocked", rx_sync_o, 1'b0);

    @(posedge clk_i); #1 loop_mode = 1'b0; src_char = 8'h00; rx_bist_en_ni = 1'b0;
    cyc(30);
    @(negedge clk_i); chk("R6 zeros no lock", rx_sync_o, 1'b0);
    @(posedge clk_i); #1 rx_bist_en_ni = 1'b1;
    cyc(2);

    src = SEED; rx_bist_en_ni = 1'b0;
    for (int i = 0; i < 300; i++) begin
      rx_valid_i = ($urandom % 3) != 0;
      src_char = src[7:0];
      @(posedge clk_i); #1;
      if (rx_valid_i) src = stp(src);
    end
    rx_valid_i = 1'b1;
    @(negedge clk_i);
    chk("R7 gaps locked", rx_sync_o, 1'b1);
    chk("R7 gaps no errors", err_cnt_o, 16'h0);

    @(posedge clk_i); #1 rx_bist_en_ni = 1'b1; loop_mode = 1'b1;
    cyc(2);
    rx_bist_en_ni = 1'b0;
    cyc(30);
    mask = 8'hFF;
    cyc(65600);
    @(negedge clk_i);
    chk("R9 saturated", err_cnt_o, 16'hFFFF);
    chk("R9 flag at saturation", rx_viol_o, 1'b1);
    @(posedge clk_i); #1 rx_bist_en_ni = 1'b1; mask = 8'h00;
    cyc(1);
    @(negedge clk_i); chk("R9 cleared", err_cnt_o, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule